// File: doc/BRIEF.md
# SD/eMMC Speed Mode and Receive Tune Control Register

This block is one 32-bit control register for an SD/eMMC host controller. Software uses it to select the bus speed mode and to program the receive sampling delay. The speed mode is a 3-bit field. The decoded mode drives the rest of the host at once, and a strobe-enable flag is raised for the enhanced-strobe variant of HS400.

The sampling delay is a 6-bit tune field. Writing that field on its own does nothing to the delay line. The new value reaches the active delay output only through an update handshake. Software writes the register with the update bit set. The bit then reads back as 1 for a fixed, parameterized number of cycles, after which hardware clears it. On that same edge the held tune value, folded into the usable delay range, becomes the active delay.

Only delay values 0 to 42 exist. Stored values from 43 upward wrap: 43 maps to 0, 44 maps to 1, and so on. Address decoding is done outside the block, so a write strobe reaches this register directly.

Top module: `sdtune_ctrl_reg`

## Requirements
- R1: After reset the register reads 0: mode 0, tune 0 and update bit clear. The active delay output is 0 and the decoded mode is SD (0).
- R2: The mode is stored in bits [2:0], the tune value in bits [13:8] and the update request in bit 15. All other bits read as 0, and writes to them have no effect.
- R3: A write whose bit 15 is 0 changes the stored tune field but leaves the active delay output unchanged.
- R4: When idle, a write with bit 15 set makes bit 15 read 1 for exactly UPD_LATENCY cycles (default 8). On the UPD_LATENCY-th rising edge after the write, bit 15 clears and the active delay takes the effective value of the tune field held just before that edge.
- R5: The effective delay equals the tune value for values 0 to 42, and the tune value minus 43 for values 43 to 63.
- R6: While an update is pending, a write still stores mode and tune. Its bit 15 neither restarts the countdown nor cancels it.
- R7: Two update requests issued one after the other for the same tune value both complete in UPD_LATENCY cycles and leave the same active delay.
- R8: The decoded mode output equals the stored mode for encodings 0, 2, 3, 4, 5 and 6 (SD, eMMC SDR, eMMC DDR, HS200, HS400, HS400 enhanced strobe). Encodings 1 and 7 decode to 0 (SD) but read back as written.
- R9: The strobe-enable output is 1 exactly when the decoded mode is 6.
- R10: A read-modify-write that changes only the mode, such as HS400 to HS400 enhanced strobe, leaves the tune field and the active delay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for this register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Current register contents |
| speed_mode_o | output | 3 | Decoded bus speed mode |
| strobe_en_o | output | 1 | Enhanced strobe enable |
| tune_active_o | output | 6 | Active receive sampling delay |

## Verification
The assertions assume two things about the inputs: the write strobe and write data are free of X and settle before each rising edge, and UPD_LATENCY is at least 1. They also assume that the data bits outside the defined fields carry no meaning. The stimulus drives every input at the falling edge. It sends fully random 32-bit write words, so the reserved bits, the mode codes 1 and 7 and tune values above 42 all occur. Writes arrive both while an update is pending and while the register is idle. Directed sequences pin down the exact countdown length, back-to-back updates and the wrap boundary at 42, 43 and 63.

// File: rtl/sdtune_pkg.sv
package sdtune_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned MODE_LSB  = 0;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned TUNE_LSB  = 8;
  localparam int unsigned TUNE_W    = 6;
  localparam int unsigned UPD_BIT   = 15;

  typedef enum logic [MODE_W-1:0] {
    SPD_SD       = 3'd0,
    SPD_MMC_SDR  = 3'd2,
    SPD_MMC_DDR  = 3'd3,
    SPD_HS200    = 3'd4,
    SPD_HS400    = 3'd5,
    SPD_HS400_ES = 3'd6
  } speed_e;
endpackage

// File: rtl/sdtune_mode_dec.sv
module sdtune_mode_dec
  import sdtune_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] raw_i,
  output speed_e            mode_o,
  output logic              strobe_o
);
  always_comb begin
    unique case (raw_i)
      3'd2:    mode_o = SPD_MMC_SDR;
      3'd3:    mode_o = SPD_MMC_DDR;
      3'd4:    mode_o = SPD_HS200;
      3'd5:    mode_o = SPD_HS400;
      3'd6:    mode_o = SPD_HS400_ES;
      default: mode_o = SPD_SD;   // 0, 1 and 7
    endcase
  end

  assign strobe_o = (raw_i == 3'd6);

  // R8
  reserved_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'd1) && (mode_o != 3'd7));
  // R9
  strobe_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (mode_o == SPD_HS400_ES));
endmodule

// File: rtl/sdtune_wrap.sv
module sdtune_wrap #(
  parameter int unsigned W     = 6,
  parameter int unsigned LIMIT = 43
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] eff_o
);
  // one subtraction is enough while 2*LIMIT exceeds the code range
  localparam logic [W-1:0] LIM = W'(LIMIT);
  assign eff_o = (raw_i >= LIM) ? raw_i - LIM : raw_i;
endmodule

// File: rtl/sdtune_upd_seq.sv
module sdtune_upd_seq #(
  parameter int unsigned LATENCY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(1));

  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> busy_q);
  // R4
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
  // R4
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
  // R6
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD);
endmodule

// File: rtl/sdtune_ctrl_reg.sv
module sdtune_ctrl_reg
  import sdtune_pkg::*;
#(
  parameter int unsigned UPD_LATENCY = 8,
  parameter int unsigned TUNE_LIMIT  = 43
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [MODE_W-1:0] speed_mode_o,
  output logic             strobe_en_o,
  output logic [TUNE_W-1:0] tune_active_o
);
  localparam int unsigned MAX_EFF = TUNE_LIMIT - 1;

  logic [MODE_W-1:0] mode_q;
  logic [TUNE_W-1:0] tune_q, active_q, tune_eff;
  logic              upd_busy, upd_done, upd_start;
  speed_e            mode_dec;

  assign upd_start = wr_en_i && wdata_i[UPD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      tune_q <= '0;
    end else if (wr_en_i) begin
      mode_q <= wdata_i[MODE_LSB +: MODE_W];
      tune_q <= wdata_i[TUNE_LSB +: TUNE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       active_q <= '0;
    else if (upd_done) active_q <= tune_eff;
  end

  sdtune_upd_seq #(.LATENCY(UPD_LATENCY)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (upd_start),
    .busy_o  (upd_busy),
    .done_o  (upd_done)
  );

  sdtune_wrap #(.W(TUNE_W), .LIMIT(TUNE_LIMIT)) u_wrap (
    .raw_i (tune_q),
    .eff_o (tune_eff)
  );

  sdtune_mode_dec u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raw_i    (mode_q),
    .mode_o   (mode_dec),
    .strobe_o (strobe_en_o)
  );

  always_comb begin
    rdata_o                        = '0;
    rdata_o[MODE_LSB +: MODE_W]    = mode_q;
    rdata_o[TUNE_LSB +: TUNE_W]    = tune_q;
    rdata_o[UPD_BIT]               = upd_busy;
  end

  assign speed_mode_o  = mode_dec;
  assign tune_active_o = active_q;

  // R3
  active_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_done |=> $stable(active_q));
  // R5
  eff_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q <= TUNE_W'(MAX_EFF));
  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[REG_W-1:UPD_BIT+1] == '0) && (rdata_o[UPD_BIT-1:TUNE_LSB+TUNE_W] == '0)
    && (rdata_o[TUNE_LSB-1:MODE_LSB+MODE_W] == '0));
  // R10
  tune_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(tune_q) && $stable(mode_q));
endmodule

// File: tb/sdtune_ctrl_reg_bench.sv
module sdtune_ctrl_reg_bench;
  localparam int LAT = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0, wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [2:0]  speed_mode_o;
  logic        strobe_en_o;
  logic [5:0]  tune_active_o;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [2:0] m_mode; logic [5:0] m_tune, m_act; logic m_busy; int m_cnt;

  always #2 clk_i = ~clk_i;

  sdtune_ctrl_reg u_sdtune_ctrl_reg (
    .clk_i, .rst_ni, .wr_en_i, .wdata_i, .rdata_o,
    .speed_mode_o, .strobe_en_o, .tune_active_o
  );

  function automatic logic [5:0] exp_eff(logic [5:0] v);
    return (v > 6'd42) ? v - 6'd43 : v;
  endfunction

  function automatic logic [2:0] exp_dec(logic [2:0] m);
    return (m == 3'd1 || m == 3'd7) ? 3'd0 : m;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " R2 rdata"}, rdata_o,
          {16'h0, m_busy, 1'b0, m_tune, 5'h0, m_mode});
    check({tag, " R8 mode"}, 32'(speed_mode_o), 32'(exp_dec(m_mode)));
    check({tag, " R9 strobe"}, 32'(strobe_en_o), 32'(exp_dec(m_mode) == 3'd6));
    check({tag, " R3/R4 active"}, 32'(tune_active_o), 32'(m_act));
  endtask

  task automatic step(logic we, logic [31:0] d);
    logic nb; int nc; logic [5:0] na;
    @(negedge clk_i);
    wr_en_i = we; wdata_i = d;
    @(posedge clk_i);
    nb = m_busy; nc = m_cnt; na = m_act;
    if (m_busy) begin
      if (m_cnt == 1) begin nb = 0; na = exp_eff(m_tune); end
      else nc = m_cnt - 1;
    end else if (we && d[15]) begin nb = 1; nc = LAT; end
    if (we) begin m_mode = d[2:0]; m_tune = d[13:8]; end
    m_busy = nb; m_cnt = nc; m_act = na;
    #1;
    wr_en_i = 1'b0;
  endtask

  function automatic logic [31:0] word(logic [2:0] m, logic [5:0] t, logic u);
    return {16'h0, u, 1'b0, t, 5'h0, m};
  endfunction

  // count idle cycles until update bit clears
  task automatic measure_update(string tag, logic [5:0] t);
    int n;
    step(1'b1, word(m_mode, t, 1'b1));
    n = 0;
    while (rdata_o[15] && n < 100) begin step(1'b0, 0); n++; end
    check({tag, " R4 latency"}, n, LAT);
    check({tag, " R5 eff"}, 32'(tune_active_o), 32'(exp_eff(t)));
  endtask

  initial begin
    m_mode = 0; m_tune = 0; m_act = 0; m_busy = 0; m_cnt = 0;
    repeat (3) @(negedge clk_i);
    #1;
    check_all("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 after reset");

    // R3: plain tune write does not move active delay
    step(1'b1, word(3'd4, 6'd20, 1'b0)); check_all("R3 plain");
    repeat (LAT + 2) step(1'b0, 0);
    check("R3 hold", 32'(tune_active_o), 0);

    // R2: reserved bits ignored
    step(1'b1, 32'hFFFF_40F8 | word(3'd2, 6'd5, 1'b0)); check_all("R2 reserved");

    // R4/R5 boundaries
    measure_update("R4 t20", 6'd20);
    measure_update("R5 t42", 6'd42);
    measure_update("R5 t43", 6'd43);
    measure_update("R5 t63", 6'd63);

    // R7: back-to-back same value
    measure_update("R7 first", 6'd17);
    measure_update("R7 second", 6'd17);
    check("R7 same", 32'(tune_active_o), 17);

    // R6: writes during pending update
    step(1'b1, word(3'd5, 6'd10, 1'b1));
    step(1'b0, 0); step(1'b0, 0);
    step(1'b1, word(3'd5, 6'd30, 1'b1)); check_all("R6 rewrite");
    step(1'b1, word(3'd5, 6'd31, 1'b0)); check_all("R6 no cancel");
    repeat (LAT) begin step(1'b0, 0); check_all("R6 drain"); end
    check("R6 result", 32'(tune_active_o), 31);

    // R10: HS400 -> HS400 ES by read-modify-write
    step(1'b1, (rdata_o & ~32'h7) | 32'd6); check_all("R10 to ES");
    check("R10 tune kept", 32'(rdata_o[13:8]), 31);
    check("R9 strobe on", 32'(strobe_en_o), 1);
    step(1'b1, (rdata_o & ~32'h7) | 32'd5); check_all("R10 to HS400");

    // R8: reserved codes
    step(1'b1, word(3'd1, 6'd3, 1'b0)); check_all("R8 code1");
    step(1'b1, word(3'd7, 6'd3, 1'b0)); check_all("R8 code7");

    // random mix
    void'($urandom(32'd4242));
    for (int i = 0; i < 600; i++) begin
      logic we; logic [31:0] d;
      we = ($urandom % 4) == 0;
      d  = $urandom;
      step(we, d);
      check_all("R2/R4/R6 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule